// File: doc/BRIEF.md
# Store Queue with Load Disambiguation and Forwarding

This block keeps the stores that are in flight in a core between allocation and the write to memory. Each store receives an age tag when it is allocated in program order. Its address and its data arrive later, through two separate write ports, in either order. When a load arrives with its address, its size and its age, the block decides combinationally, in the same cycle, whether the load takes its value from a buffered store, goes to the data cache, or has to wait and try again.

A store that has retired becomes senior. Senior stores leave from the head one per cycle, oldest first, on a commit port. A fence input holds back every later load until all older stores have left. A flush input cuts off speculative stores from a given tag onward. A load whose older stores all have known, non-matching addresses can proceed even while some of their data is still missing.

Top module: `store_queue_fwd`

## Requirements
- R1: `alloc_tag` gives the next age tag. It is `$clog2(DEPTH)+1` bits wide, starts at 0 after reset and advances by one per accepted allocation, modulo 2*DEPTH. `alloc_ready` is low while DEPTH stores are held. An allocation request that arrives while `alloc_ready` is low is ignored and leaves `alloc_tag` unchanged.
- R2: A store's address (with size) and its data are written through independent ports, addressed by age tag, in either order. A store can forward only once both have been written.
- R3: A load whose older stores all have known addresses in other 8-byte words answers `ld_resp` = 0 (go to cache), with `ld_data` = 0.
- R4: Take the youngest store older than the load. If its word matches the load's word, its data is written, and its bytes cover every byte the load reads, the load answers `ld_resp` = 1 (forward). `ld_data` then holds the load's bytes, right-aligned and zero-extended. Store data is held right-aligned from the store's first byte.
- R5: If the youngest older store that is either unresolved or matching has an unknown address, the load answers `ld_resp` = 2 (wait). An unresolved store that is older than the youngest match does not block forwarding.
- R6: A load whose youngest older match has no data yet answers wait (2), not cache.
- R7: Matching compares address bits [AW-1:3]. Bits [2:0] are the byte offset. Size code s means 2^s bytes, and no access crosses an 8-byte word. A match whose bytes do not fully cover the load answers wait (2).
- R8: Stores whose tag is equal to or younger than `ld_tag` have no effect on the load's answer. `ld_tag` is the value `alloc_tag` had when the load was dispatched, and it must lie within the held window.
- R9: A `ret_valid` pulse makes the oldest non-senior store senior. A senior store at the head appears on `cm_valid`/`cm_addr`/`cm_size`/`cm_data` in the cycle after its retire pulse. It leaves at the next edge, one store per cycle, in program order.
- R10: From the cycle after a `fence_valid` pulse, every load with a tag at or after the fence point answers wait. This lasts until all stores allocated up to and including the fence cycle have committed. A fence on an empty queue blocks nothing.
- R11: A `flush_valid` pulse with `flush_tag` discards every non-senior store whose tag is equal to or younger than `flush_tag`, and `alloc_tag` becomes `flush_tag`. Senior stores are never discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Request to allocate a store |
| alloc_ready | output | 1 | Room for another store |
| alloc_tag | output | PTR_W | Tag given to the next allocation |
| sta_valid | input | 1 | Store address write |
| sta_tag | input | PTR_W | Tag of the store taking the address |
| sta_addr | input | AW | Store byte address |
| sta_size | input | 2 | Store size code |
| std_valid | input | 1 | Store data write |
| std_tag | input | PTR_W | Tag of the store taking the data |
| std_data | input | 64 | Store data, right-aligned |
| ret_valid | input | 1 | Retire the oldest non-senior store |
| fence_valid | input | 1 | Fence point at the current allocation point |
| flush_valid | input | 1 | Discard speculative stores |
| flush_tag | input | PTR_W | Oldest tag to discard |
| ld_valid | input | 1 | Load lookup |
| ld_tag | input | PTR_W | Load age (allocation point at dispatch) |
| ld_addr | input | AW | Load byte address |
| ld_size | input | 2 | Load size code |
| ld_resp | output | 2 | 0 cache, 1 forward, 2 wait |
| ld_data | output | 64 | Forwarded value |
| cm_valid | output | 1 | Head store commits this cycle |
| cm_addr | output | AW | Committing address |
| cm_size | output | 2 | Committing size code |
| cm_data | output | 64 | Committing data |

## Verification
A wrong address-valid or data-valid bit shows up in the same cycle as a load answering cache or forward where wait is due, or waiting forever. A wrong head or retire pointer shows up on the commit port one cycle after a retire pulse, as a missing, repeated or out-of-order store. A wrong tail shows up at once in `alloc_tag` and in which stores count as older than a later load. Sweeping every store/load offset and size pair inside one word exposes any error in the coverage test or the byte extraction on the first vector that touches it.

// File: rtl/sbq_pkg.sv
`timescale 1ns/1ps
package sbq_pkg;
  localparam int OFF_W  = 3;
  localparam int DATA_W = 64;

  typedef enum logic [1:0] {
    LD_CACHE = 2'd0,
    LD_FWD   = 2'd1,
    LD_WAIT  = 2'd2
  } ld_resp_e;

  function automatic logic [3:0] size_bytes(input logic [1:0] sz);
    return 4'd1 << sz;
  endfunction

  // load bytes [l_off, l_off+lb) lie inside store bytes [s_off, s_off+sb)
  function automatic logic covers(input logic [OFF_W-1:0] s_off, input logic [1:0] s_sz,
                                  input logic [OFF_W-1:0] l_off, input logic [1:0] l_sz);
    logic [4:0] s_end;
    logic [4:0] l_end;
    s_end = 5'(s_off) + 5'(size_bytes(s_sz));
    l_end = 5'(l_off) + 5'(size_bytes(l_sz));
    return (l_off >= s_off) && (l_end <= s_end);
  endfunction

  function automatic logic [DATA_W-1:0] extract(input logic [DATA_W-1:0] d,
                                                input logic [OFF_W-1:0] skip,
                                                input logic [1:0] l_sz);
    logic [DATA_W-1:0] sh;
    logic [DATA_W-1:0] m;
    sh = d >> {skip, 3'b000};
    m  = (l_sz == 2'd3) ? '1 : ((64'd1 << {size_bytes(l_sz), 3'b000}) - 64'd1);
    return sh & m;
  endfunction
endpackage

// File: rtl/sbq_ptrs.sv
`timescale 1ns/1ps
module sbq_ptrs #(
  parameter int DEPTH = 4,
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_valid,
  input  logic             ret_valid,
  input  logic             fence_valid,
  input  logic             flush_valid,
  input  logic [PTR_W-1:0] flush_tag,
  input  logic             senior_head,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [PTR_W-1:0] ret_ptr,
  output logic [PTR_W-1:0] count,
  output logic             full,
  output logic             alloc_fire,
  output logic             ret_fire,
  output logic             commit_fire,
  output logic             fence_act,
  output logic [PTR_W-1:0] fence_tag
);
  logic [PTR_W-1:0] head_n, tail_n, ret_n, fence_tag_n;
  logic [PTR_W-1:0] fl_dist, rt_dist;
  logic             fence_act_n;

  assign count       = tail - head;
  assign full        = (count == PTR_W'(DEPTH));
  assign alloc_fire  = alloc_valid && !full && !flush_valid;
  assign ret_fire    = ret_valid && (ret_ptr != tail);
  assign commit_fire = (count != '0) && senior_head;

  always_comb begin
    head_n  = head + {{(PTR_W-1){1'b0}}, commit_fire};
    ret_n   = ret_ptr + {{(PTR_W-1){1'b0}}, ret_fire};
    tail_n  = tail + {{(PTR_W-1){1'b0}}, alloc_fire};
    fl_dist = flush_tag - head;
    rt_dist = ret_n - head;
    if (flush_valid && (fl_dist <= count))
      tail_n = (fl_dist < rt_dist) ? ret_n : flush_tag;   // never cut a senior store
    fence_act_n = fence_act;
    fence_tag_n = fence_tag;
    if (fence_act && (head_n == fence_tag)) fence_act_n = 1'b0;
    if (flush_valid && ((fence_tag - head) > (tail_n - head))) fence_tag_n = tail_n;
    if (fence_valid) begin
      fence_act_n = 1'b1;
      fence_tag_n = tail_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head      <= '0;
      tail      <= '0;
      ret_ptr   <= '0;
      fence_act <= 1'b0;
      fence_tag <= '0;
    end else begin
      head      <= head_n;
      tail      <= tail_n;
      ret_ptr   <= ret_n;
      fence_act <= fence_act_n;
      fence_tag <= fence_tag_n;
    end
  end
endmodule

// File: rtl/sbq_entries.sv
`timescale 1ns/1ps
module sbq_entries
  import sbq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 12,
  parameter int IDX_W = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          alloc_fire,
  input  logic [IDX_W-1:0]              alloc_idx,
  input  logic                          sta_valid,
  input  logic [IDX_W-1:0]              sta_idx,
  input  logic [AW-1:0]                 sta_addr,
  input  logic [1:0]                    sta_size,
  input  logic                          std_valid,
  input  logic [IDX_W-1:0]              std_idx,
  input  logic [DATA_W-1:0]             std_data,
  input  logic                          ret_fire,
  input  logic [IDX_W-1:0]              ret_idx,
  output logic [DEPTH-1:0]              addr_v,
  output logic [DEPTH-1:0]              data_v,
  output logic [DEPTH-1:0]              senior,
  output logic [DEPTH-1:0][AW-1:0]      addr,
  output logic [DEPTH-1:0][1:0]         size,
  output logic [DEPTH-1:0][DATA_W-1:0]  data
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic              av_q, dv_q, sn_q;
    logic [AW-1:0]     a_q;
    logic [1:0]        s_q;
    logic [DATA_W-1:0] d_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        av_q <= 1'b0;
        dv_q <= 1'b0;
        sn_q <= 1'b0;
        a_q  <= '0;
        s_q  <= '0;
        d_q  <= '0;
      end else begin
        if (alloc_fire && alloc_idx == IDX_W'(i)) begin
          av_q <= 1'b0;
          dv_q <= 1'b0;
          sn_q <= 1'b0;
        end
        if (sta_valid && sta_idx == IDX_W'(i)) begin
          av_q <= 1'b1;
          a_q  <= sta_addr;
          s_q  <= sta_size;
        end
        if (std_valid && std_idx == IDX_W'(i)) begin
          dv_q <= 1'b1;
          d_q  <= std_data;
        end
        if (ret_fire && ret_idx == IDX_W'(i)) sn_q <= 1'b1;
      end
    end

    assign addr_v[i] = av_q;
    assign data_v[i] = dv_q;
    assign senior[i] = sn_q;
    assign addr[i]   = a_q;
    assign size[i]   = s_q;
    assign data[i]   = d_q;
  end
endmodule

// File: rtl/sbq_lookup.sv
`timescale 1ns/1ps
module sbq_lookup
  import sbq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 12,
  parameter int PTR_W = 3,
  parameter int IDX_W = 2
) (
  input  logic [PTR_W-1:0]              head,
  input  logic [PTR_W-1:0]              count,
  input  logic [DEPTH-1:0]              addr_v,
  input  logic [DEPTH-1:0]              data_v,
  input  logic [DEPTH-1:0][AW-1:0]      addr,
  input  logic [DEPTH-1:0][1:0]         size,
  input  logic [DEPTH-1:0][DATA_W-1:0]  data,
  input  logic                          fence_act,
  input  logic [PTR_W-1:0]              fence_tag,
  input  logic                          ld_valid,
  input  logic [PTR_W-1:0]              ld_tag,
  input  logic [AW-1:0]                 ld_addr,
  input  logic [1:0]                    ld_size,
  output logic                          hit_found,
  output logic [IDX_W-1:0]              hit_idx,
  output logic                          fence_block,
  output ld_resp_e                      resp,
  output logic [DATA_W-1:0]             ld_data
);
  logic [PTR_W-1:0] ld_dist, fc_dist;
  logic [IDX_W-1:0] idx;
  logic [OFF_W-1:0] s_off, l_off;

  assign ld_dist     = ld_tag - head;
  assign fc_dist     = fence_tag - head;
  assign fence_block = fence_act && (head != fence_tag) && (ld_dist >= fc_dist);

  // walk oldest to youngest; the last candidate seen is the youngest older one
  always_comb begin
    hit_found = 1'b0;
    hit_idx   = '0;
    idx       = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head[IDX_W-1:0] + IDX_W'(k);
      if ((PTR_W'(k) < count) && (PTR_W'(k) < ld_dist) &&
          (!addr_v[idx] || (addr[idx][AW-1:OFF_W] == ld_addr[AW-1:OFF_W]))) begin
        hit_found = 1'b1;
        hit_idx   = idx;
      end
    end
  end

  assign s_off = addr[hit_idx][OFF_W-1:0];
  assign l_off = ld_addr[OFF_W-1:0];

  always_comb begin
    resp    = LD_CACHE;
    ld_data = '0;
    if (ld_valid) begin
      if (fence_block)                 resp = LD_WAIT;
      else if (!hit_found)             resp = LD_CACHE;
      else if (!addr_v[hit_idx])       resp = LD_WAIT;
      else if (data_v[hit_idx] && covers(s_off, size[hit_idx], l_off, ld_size)) begin
        resp    = LD_FWD;
        ld_data = extract(data[hit_idx], l_off - s_off, ld_size);
      end else                         resp = LD_WAIT;
    end
  end
endmodule

// File: rtl/store_queue_fwd.sv
`timescale 1ns/1ps
module store_queue_fwd
  import sbq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 12,
  parameter int PTR_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  output logic [PTR_W-1:0]  alloc_tag,
  input  logic              sta_valid,
  input  logic [PTR_W-1:0]  sta_tag,
  input  logic [AW-1:0]     sta_addr,
  input  logic [1:0]        sta_size,
  input  logic              std_valid,
  input  logic [PTR_W-1:0]  std_tag,
  input  logic [63:0]       std_data,
  input  logic              ret_valid,
  input  logic              fence_valid,
  input  logic              flush_valid,
  input  logic [PTR_W-1:0]  flush_tag,
  input  logic              ld_valid,
  input  logic [PTR_W-1:0]  ld_tag,
  input  logic [AW-1:0]     ld_addr,
  input  logic [1:0]        ld_size,
  output logic [1:0]        ld_resp,
  output logic [63:0]       ld_data,
  output logic              cm_valid,
  output logic [AW-1:0]     cm_addr,
  output logic [1:0]        cm_size,
  output logic [63:0]       cm_data
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [PTR_W-1:0] head, tail, ret_ptr, count, fence_tag;
  logic             full, alloc_fire, ret_fire, commit_fire, fence_act;
  logic [IDX_W-1:0] head_idx, ret_idx;
  logic [DEPTH-1:0] addr_v, data_v, senior;
  logic [DEPTH-1:0][AW-1:0]     addr;
  logic [DEPTH-1:0][1:0]        size;
  logic [DEPTH-1:0][DATA_W-1:0] data;
  logic             hit_found, fence_block;
  logic [IDX_W-1:0] hit_idx;
  ld_resp_e         resp;

  assign head_idx = head[IDX_W-1:0];
  assign ret_idx  = ret_ptr[IDX_W-1:0];

  sbq_ptrs #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .ret_valid(ret_valid),
    .fence_valid(fence_valid), .flush_valid(flush_valid), .flush_tag(flush_tag),
    .senior_head(senior[head_idx]), .head(head), .tail(tail), .ret_ptr(ret_ptr),
    .count(count), .full(full), .alloc_fire(alloc_fire), .ret_fire(ret_fire),
    .commit_fire(commit_fire), .fence_act(fence_act), .fence_tag(fence_tag)
  );

  sbq_entries #(.DEPTH(DEPTH), .AW(AW), .IDX_W(IDX_W)) u_entries (
    .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire), .alloc_idx(tail[IDX_W-1:0]),
    .sta_valid(sta_valid), .sta_idx(sta_tag[IDX_W-1:0]), .sta_addr(sta_addr),
    .sta_size(sta_size), .std_valid(std_valid), .std_idx(std_tag[IDX_W-1:0]),
    .std_data(std_data), .ret_fire(ret_fire), .ret_idx(ret_idx),
    .addr_v(addr_v), .data_v(data_v), .senior(senior), .addr(addr), .size(size), .data(data)
  );

  sbq_lookup #(.DEPTH(DEPTH), .AW(AW), .PTR_W(PTR_W), .IDX_W(IDX_W)) u_lookup (
    .head(head), .count(count), .addr_v(addr_v), .data_v(data_v), .addr(addr),
    .size(size), .data(data), .fence_act(fence_act), .fence_tag(fence_tag),
    .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_addr(ld_addr), .ld_size(ld_size),
    .hit_found(hit_found), .hit_idx(hit_idx), .fence_block(fence_block),
    .resp(resp), .ld_data(ld_data)
  );

  assign alloc_ready = !full && !flush_valid;
  assign alloc_tag   = tail;
  assign ld_resp     = resp;
  assign cm_valid    = commit_fire;
  assign cm_addr     = addr[head_idx];
  assign cm_size     = size[head_idx];
  assign cm_data     = data[head_idx];
endmodule

// File: rtl/sbq_chk.sv
`timescale 1ns/1ps
module sbq_chk #(
  parameter int DEPTH = 4,
  parameter int PTR_W = 3,
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             flush_valid,
  input logic             full,
  input logic [PTR_W-1:0] tail,
  input logic [PTR_W-1:0] head,
  input logic             ld_valid,
  input logic [1:0]       ld_resp,
  input logic             hit_found,
  input logic [IDX_W-1:0] hit_idx,
  input logic             fence_block,
  input logic [DEPTH-1:0] addr_v,
  input logic [DEPTH-1:0] data_v,
  input logic [DEPTH-1:0] senior,
  input logic             cm_valid
);
  assert_full_holds_tail_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (full && alloc_valid && !flush_valid) |=> (tail == $past(tail)));

  assert_cache_no_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_resp == 2'd0) |-> !hit_found);

  assert_fwd_has_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_resp == 2'd1) |-> (hit_found && addr_v[hit_idx] && data_v[hit_idx]));

  assert_unresolved_waits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && hit_found && !addr_v[hit_idx]) |-> (ld_resp == 2'd2));

  assert_commit_complete_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |-> (senior[head[IDX_W-1:0]] && addr_v[head[IDX_W-1:0]] && data_v[head[IDX_W-1:0]]));

  assert_commit_advances_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |=> (head == $past(head) + PTR_W'(1)));

  assert_fence_waits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && fence_block) |-> (ld_resp == 2'd2));
endmodule

bind store_queue_fwd sbq_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .flush_valid(flush_valid),
  .full(full), .tail(tail), .head(head), .ld_valid(ld_valid), .ld_resp(ld_resp),
  .hit_found(hit_found), .hit_idx(hit_idx), .fence_block(fence_block),
  .addr_v(addr_v), .data_v(data_v), .senior(senior), .cm_valid(cm_valid)
);

// File: tb/test_store_queue_fwd.sv
`timescale 1ns/1ps
module test_store_queue_fwd;
  localparam int DEPTH = 4;
  localparam int AW    = 12;
  localparam int PW    = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic alloc_valid, alloc_ready;
  logic [PW-1:0] alloc_tag;
  logic sta_valid; logic [PW-1:0] sta_tag; logic [AW-1:0] sta_addr; logic [1:0] sta_size;
  logic std_valid; logic [PW-1:0] std_tag; logic [63:0] std_data;
  logic ret_valid, fence_valid, flush_valid; logic [PW-1:0] flush_tag;
  logic ld_valid; logic [PW-1:0] ld_tag; logic [AW-1:0] ld_addr; logic [1:0] ld_size;
  logic [1:0] ld_resp; logic [63:0] ld_data;
  logic cm_valid; logic [AW-1:0] cm_addr; logic [1:0] cm_size; logic [63:0] cm_data;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [PW-1:0] hd = '0;
  logic [PW-1:0] tl = '0;

  store_queue_fwd #(.DEPTH(DEPTH), .AW(AW)) i_store_queue_fwd (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_tag(alloc_tag), .sta_valid(sta_valid), .sta_tag(sta_tag), .sta_addr(sta_addr),
    .sta_size(sta_size), .std_valid(std_valid), .std_tag(std_tag), .std_data(std_data),
    .ret_valid(ret_valid), .fence_valid(fence_valid), .flush_valid(flush_valid),
    .flush_tag(flush_tag), .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_addr(ld_addr),
    .ld_size(ld_size), .ld_resp(ld_resp), .ld_data(ld_data), .cm_valid(cm_valid),
    .cm_addr(cm_addr), .cm_size(cm_size), .cm_data(cm_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic alloc(output logic [PW-1:0] t);
    alloc_valid = 1'b1;
    #1;
    chk(alloc_ready == 1'b1 && alloc_tag == tl, "R1", "alloc tag", 64'(alloc_tag), 64'(tl));
    t = tl;
    @(negedge clk);
    alloc_valid = 1'b0;
    tl = tl + 1'b1;
  endtask

  task automatic wr_addr(input logic [PW-1:0] t, input logic [AW-1:0] a, input logic [1:0] s);
    sta_valid = 1'b1; sta_tag = t; sta_addr = a; sta_size = s;
    @(negedge clk);
    sta_valid = 1'b0;
  endtask

  task automatic wr_data(input logic [PW-1:0] t, input logic [63:0] d);
    std_valid = 1'b1; std_tag = t; std_data = d;
    @(negedge clk);
    std_valid = 1'b0;
  endtask

  task automatic flush_to(input logic [PW-1:0] t);
    flush_valid = 1'b1; flush_tag = t;
    @(negedge clk);
    flush_valid = 1'b0;
    tl = t;
  endtask

  task automatic fence();
    fence_valid = 1'b1;
    @(negedge clk);
    fence_valid = 1'b0;
  endtask

  task automatic retire_commit(input logic [AW-1:0] ea, input logic [1:0] es, input logic [63:0] ed);
    ret_valid = 1'b1;
    @(negedge clk);
    ret_valid = 1'b0;
    #1;
    chk(cm_valid == 1'b1, "R9", "commit valid after retire", 64'(cm_valid), 64'd1);
    chk(cm_addr == ea && cm_size == es, "R9", "commit address", 64'(cm_addr), 64'(ea));
    chk(cm_data == ed, "R9", "commit data", cm_data, ed);
    @(negedge clk);
    hd = hd + 1'b1;
  endtask

  task automatic query(input logic [PW-1:0] t, input logic [AW-1:0] a, input logic [1:0] s,
                       input logic [1:0] er, input logic [63:0] ed, input string req);
    ld_valid = 1'b1; ld_tag = t; ld_addr = a; ld_size = s;
    #2;
    chk(ld_resp == er, req, "load response", 64'(ld_resp), 64'(er));
    chk(ld_data == ed, req, "load data", ld_data, ed);
    ld_valid = 1'b0;
  endtask

  // bytes a load would see from a right-aligned store, computed byte by byte
  function automatic logic [63:0] pick(input logic [63:0] d, input int s_off, input int l_off, input int lb);
    logic [63:0] r = '0;
    for (int m = 0; m < lb; m++) r[8*m +: 8] = d[8*(l_off - s_off + m) +: 8];
    return r;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [PW-1:0] t0, t1, t2, t3, tx;
    logic [63:0] dv;
    rst_n = 1'b0;
    alloc_valid = 0; sta_valid = 0; std_valid = 0; ret_valid = 0;
    fence_valid = 0; flush_valid = 0; ld_valid = 0;
    sta_tag = '0; sta_addr = '0; sta_size = '0; std_tag = '0; std_data = '0;
    flush_tag = '0; ld_tag = '0; ld_addr = '0; ld_size = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk(alloc_ready == 1'b1 && alloc_tag == '0, "R1", "reset alloc state", 64'(alloc_tag), 64'd0);
    chk(cm_valid == 1'b0, "R9", "reset commit idle", 64'(cm_valid), 64'd0);
    query(tl, 12'h100, 2'd3, 2'd0, 64'd0, "R3");

    // R1: fill, then an ignored allocation while full
    alloc(t0); alloc(t1); alloc(t2); alloc(t3);
    alloc_valid = 1'b1;
    #1;
    chk(alloc_ready == 1'b0, "R1", "ready low when full", 64'(alloc_ready), 64'd0);
    @(negedge clk);
    alloc_valid = 1'b0;
    #1;
    chk(alloc_tag == tl, "R1", "tag held when full", 64'(alloc_tag), 64'(tl));
    @(negedge clk);
    flush_to(hd);
    #1;
    chk(alloc_tag == hd, "R11", "flush to head empties", 64'(alloc_tag), 64'(hd));
    @(negedge clk);

    // R4/R7/R8 sweep over every in-word store and load shape
    for (int ss = 0; ss < 4; ss++) begin
      for (int so = 0; so < 8; so++) begin
        if (so + (1 << ss) <= 8) begin
          for (int ls = 0; ls < 4; ls++) begin
            for (int lo = 0; lo < 8; lo++) begin
              if (lo + (1 << ls) <= 8) begin
                bit cov;
                dv = {8{8'(17 * so + lo + 1)}} ^ 64'h0123456789ABCDEF;
                cov = (lo >= so) && (lo + (1 << ls) <= so + (1 << ss));
                alloc(t0);
                wr_addr(t0, 12'h100 | 12'(so), 2'(ss));
                wr_data(t0, dv);
                if (cov) query(tl, 12'h100 | 12'(lo), 2'(ls), 2'd1, pick(dv, so, lo, 1 << ls), "R4");
                else     query(tl, 12'h100 | 12'(lo), 2'(ls), 2'd2, 64'd0, "R7");
                query(t0, 12'h100 | 12'(lo), 2'(ls), 2'd0, 64'd0, "R8");
                query(tl, 12'h108 | 12'(lo), 2'(ls), 2'd0, 64'd0, "R3");
                flush_to(hd);
              end
            end
          end
        end
      end
    end

    // R5: unresolved older than the match does not block
    alloc(t0); alloc(t1);
    wr_addr(t1, 12'h600, 2'd3); wr_data(t1, 64'hAAAA_BBBB_CCCC_DDDD);
    query(tl, 12'h600, 2'd3, 2'd1, 64'hAAAA_BBBB_CCCC_DDDD, "R5");
    query(tl, 12'h700, 2'd3, 2'd2, 64'd0, "R5");
    query(t1, 12'h600, 2'd3, 2'd2, 64'd0, "R5");
    wr_addr(t0, 12'h608, 2'd3);
    query(tl, 12'h700, 2'd3, 2'd0, 64'd0, "R5");
    flush_to(hd);

    // R5: unresolved younger than the match blocks until resolved
    alloc(t0); alloc(t1);
    wr_addr(t0, 12'h600, 2'd3); wr_data(t0, 64'h1111_2222_3333_4444);
    query(tl, 12'h600, 2'd2, 2'd2, 64'd0, "R5");
    wr_addr(t1, 12'h640, 2'd3);
    query(tl, 12'h604, 2'd2, 2'd1, 64'h0000_0000_1111_2222, "R5");
    flush_to(hd);

    // R6 then R2: address before data, and data before address
    alloc(t0);
    wr_addr(t0, 12'h680, 2'd2);
    query(tl, 12'h680, 2'd2, 2'd2, 64'd0, "R6");
    wr_data(t0, 64'h0000_0000_CAFE_F00D);
    query(tl, 12'h680, 2'd1, 2'd1, 64'h0000_0000_0000_F00D, "R2");
    alloc(t1);
    wr_data(t1, 64'h0000_0000_0000_00EE);
    query(tl, 12'h6A0, 2'd0, 2'd2, 64'd0, "R2");
    wr_addr(t1, 12'h6A3, 2'd0);
    query(tl, 12'h6A3, 2'd0, 2'd1, 64'h0000_0000_0000_00EE, "R2");
    flush_to(hd);

    // R4: youngest older match wins
    alloc(t0); alloc(t1);
    wr_addr(t0, 12'h6C0, 2'd3); wr_data(t0, 64'h0101_0101_0101_0101);
    wr_addr(t1, 12'h6C0, 2'd3); wr_data(t1, 64'h0202_0202_0202_0202);
    query(tl, 12'h6C0, 2'd3, 2'd1, 64'h0202_0202_0202_0202, "R4");
    query(t1, 12'h6C0, 2'd3, 2'd1, 64'h0101_0101_0101_0101, "R8");
    flush_to(hd);

    // R11: partial flush keeps older stores
    alloc(t0); alloc(t1); alloc(t2);
    wr_addr(t0, 12'h400, 2'd3); wr_data(t0, 64'h0000_0000_0000_0A0A);
    wr_addr(t1, 12'h400, 2'd3); wr_data(t1, 64'h0000_0000_0000_0B0B);
    wr_addr(t2, 12'h400, 2'd3); wr_data(t2, 64'h0000_0000_0000_0C0C);
    flush_to(t1);
    #1;
    chk(alloc_tag == t1, "R11", "tail after partial flush", 64'(alloc_tag), 64'(t1));
    query(tl, 12'h400, 2'd3, 2'd1, 64'h0000_0000_0000_0A0A, "R11");
    @(negedge clk);
    alloc(tx);
    query(tl, 12'h400, 2'd3, 2'd2, 64'd0, "R11");
    flush_to(hd);

    // R9: in-order commit
    alloc(t0); alloc(t1);
    wr_addr(t0, 12'h504, 2'd2); wr_data(t0, 64'h0000_0000_DEAD_BEEF);
    wr_addr(t1, 12'h50A, 2'd1); wr_data(t1, 64'h0000_0000_0000_1234);
    #1;
    chk(cm_valid == 1'b0, "R9", "no commit before retire", 64'(cm_valid), 64'd0);
    @(negedge clk);
    retire_commit(12'h504, 2'd2, 64'h0000_0000_DEAD_BEEF);
    retire_commit(12'h50A, 2'd1, 64'h0000_0000_0000_1234);
    #1;
    chk(cm_valid == 1'b0 && alloc_tag == hd, "R9", "queue drained", 64'(alloc_tag), 64'(hd));
    query(tl, 12'h504, 2'd2, 2'd0, 64'd0, "R9");
    @(negedge clk);

    // R10: fence blocks later loads until older stores drain
    fence();
    query(tl, 12'h300, 2'd3, 2'd0, 64'd0, "R10");
    alloc(t0);
    wr_addr(t0, 12'h200, 2'd3); wr_data(t0, 64'h55);
    query(tl, 12'h300, 2'd3, 2'd0, 64'd0, "R10");
    fence();
    query(tl, 12'h300, 2'd3, 2'd2, 64'd0, "R10");
    retire_commit(12'h200, 2'd3, 64'h55);
    query(tl, 12'h300, 2'd3, 2'd0, 64'd0, "R10");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule